// File: doc/BRIEF.md
# Pattern-Ink Memory Write Front End

This block sits between a memory controller's request port and a 32-bit memory array that has one write enable per data bit plus one stored parity bit per word. It presents the same physical storage through two address windows. A write through the replace window stores the source word as it is. A write through the ink window treats the source word as a coverage mask. Wherever the mask holds a one, the stored bit takes the matching bit of a programmable 32-bit ink pattern. Wherever the mask holds a zero, the stored bit is not touched. Rendering software uses the ink window to lay glyph bitmaps over an existing page image in one write, with no read-modify-write and in any colour pattern.

The masking is done only by the per-bit write enables: each enable is the inverted mask bit, and the array data lines carry the pattern. Because such partial writes leave the word's parity bit stale, writes through the ink window do not update the parity bit, and reads through the ink window never report a parity error. A third window, selected by the top address bit, holds the ink pattern register.

Top module: `inkmask_front`

## Requirements
- R1: After reset the ink pattern register holds all zeros and `rsp_valid` is low.
- R2: A write through the replace window (address bit PHYS_W+1 = 0, bit PHYS_W = 0) stores the full source word in the addressed array word.
- R3: A write through the ink window (bit PHYS_W+1 = 0, bit PHYS_W = 1) leaves every stored bit whose source bit is 0 unchanged.
- R4: A write through the ink window sets every stored bit whose source bit is 1 to the matching bit of the ink pattern register.
- R5: During an ink-window write, `arr_bit_we_n[i]` equals the inverse of source bit i (active low). During a replace write all enables are 0. With no write, all enables are 1.
- R6: Both memory windows address the same physical word: `arr_addr` equals the low PHYS_W bits of `req_addr`.
- R7: An address with bit PHYS_W+1 set selects the ink pattern register. A write loads it. A read returns its value. Neither access drives any array write enable or the array read strobe.
- R8: A replace write writes the parity bit as the XOR of the source word (`arr_par_we_n` = 0, `arr_wpar` = XOR of the data). An ink write leaves the parity bit unwritten (`arr_par_we_n` = 1).
- R9: A replace-window read reports `rsp_par_err` = XOR of the returned word and its stored parity bit. Ink-window reads and register reads never report a parity error.
- R10: A read through either window returns the raw stored word, with `rsp_valid` high exactly in the cycle after the read request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | PHYS_W+2 | Word address: bit PHYS_W+1 selects the register, bit PHYS_W selects the ink window |
| req_wdata | input | DW | Write data (mask in the ink window) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| rsp_par_err | output | 1 | Parity error on a replace-window read |
| arr_addr | output | PHYS_W | Physical word address to the array |
| arr_rd | output | 1 | Array read strobe, data returned next cycle |
| arr_bit_we_n | output | DW | Per-bit active-low write enables |
| arr_wdata | output | DW | Data to the array |
| arr_par_we_n | output | 1 | Active-low parity-bit write enable |
| arr_wpar | output | 1 | Parity bit to write |
| arr_rdata | input | DW | Array read data, one cycle after `arr_rd` |
| arr_rpar | input | 1 | Stored parity bit, one cycle after `arr_rd` |

## Verification
The bench fills every word of a small array through the replace window, then applies several ink patterns (all ones, all zeros, alternating, irregular) with masks that vary per word. It checks separately that masked-off bits keep their old value and that masked-in bits take the pattern. A design that drove the bus data instead of the pattern, or that did not invert the mask, would corrupt one of the two bit sets. Each word is also read back through the replace window after an ink write. The parity flag must then follow the arithmetic mismatch between the new word and the last parity the bench wrote. A design that refreshed parity on ink writes, or checked parity on ink reads, shows a wrong flag. Pattern register accesses are watched at the array pins, so any leak into the array appears as a stray enable or read strobe.

// File: rtl/inkmask_pkg.sv
package inkmask_pkg;
  typedef enum logic [1:0] {
    VIEW_REPLACE = 2'd0,
    VIEW_INK     = 2'd1,
    VIEW_REG     = 2'd2
  } view_e;
endpackage

// File: rtl/inkmask_decode.sv
module inkmask_decode
  import inkmask_pkg::*;
#(
  parameter int PHYS_W = 23,
  localparam int AW    = PHYS_W + 2
) (
  input  logic [AW-1:0]     addr,
  output view_e             view,
  output logic [PHYS_W-1:0] word
);
  function automatic view_e view_of(input logic [AW-1:0] a);
    if (a[AW-1])       return VIEW_REG;
    else if (a[PHYS_W]) return VIEW_INK;
    else               return VIEW_REPLACE;
  endfunction

  assign view = view_of(addr);
  assign word = addr[PHYS_W-1:0];
endmodule

// File: rtl/inkmask_pattern_reg.sv
module inkmask_pattern_reg #(
  parameter int          DW      = 32,
  parameter logic [DW-1:0] PAT_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= PAT_RST;
    else if (load) q <= din;
  end
endmodule

// File: rtl/inkmask_lane_gen.sv
module inkmask_lane_gen
  import inkmask_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          is_write,
  input  view_e         view,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] pattern,
  output logic [DW-1:0] bit_we_n,
  output logic [DW-1:0] wdata,
  output logic          par_we_n,
  output logic          wpar
);
  function automatic logic lane_we_n(input logic wr, input view_e v, input logic s);
    if (!wr) return 1'b1;
    case (v)
      VIEW_REPLACE: return 1'b0;
      VIEW_INK:     return ~s;
      default:      return 1'b1;
    endcase
  endfunction

  function automatic logic lane_data(input view_e v, input logic s, input logic p);
    return (v == VIEW_INK) ? p : s;
  endfunction

  for (genvar g = 0; g < DW; g++) begin : g_lane
    assign bit_we_n[g] = lane_we_n(is_write, view, src[g]);
    assign wdata[g]    = lane_data(view, src[g], pattern[g]);
  end

  assign par_we_n = !(is_write && view == VIEW_REPLACE);
  assign wpar     = ^src;
endmodule

// File: rtl/inkmask_parity_guard.sv
module inkmask_parity_guard
  import inkmask_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  view_e         rd_view,
  input  logic [DW-1:0] arr_rdata,
  input  logic          arr_rpar,
  input  logic [DW-1:0] pattern,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_par_err
);
  logic  pend_q;
  view_e pend_view_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_view_q <= VIEW_REPLACE;
    end else begin
      pend_q      <= rd_req;
      pend_view_q <= rd_view;
    end
  end

  logic check_en;
  assign check_en    = pend_q && (pend_view_q == VIEW_REPLACE);
  assign rsp_valid   = pend_q;
  assign rsp_rdata   = (pend_view_q == VIEW_REG) ? pattern : arr_rdata;
  assign rsp_par_err = check_en && ((^arr_rdata) ^ arr_rpar);
endmodule

// File: rtl/inkmask_front.sv
module inkmask_front
  import inkmask_pkg::*;
#(
  parameter int            PHYS_W  = 23,
  parameter int            DW      = 32,
  parameter logic [DW-1:0] PAT_RST = '0,
  localparam int           AW      = PHYS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_par_err,
  output logic [PHYS_W-1:0] arr_addr,
  output logic              arr_rd,
  output logic [DW-1:0]     arr_bit_we_n,
  output logic [DW-1:0]     arr_wdata,
  output logic              arr_par_we_n,
  output logic              arr_wpar,
  input  logic [DW-1:0]     arr_rdata,
  input  logic              arr_rpar
);
  view_e         view;
  logic [DW-1:0] pattern;
  logic          mem_wr, reg_wr, any_rd;

  inkmask_decode #(.PHYS_W(PHYS_W)) u_dec (
    .addr(req_addr), .view(view), .word(arr_addr)
  );

  assign mem_wr = req_valid && req_write && (view != VIEW_REG);
  assign reg_wr = req_valid && req_write && (view == VIEW_REG);
  assign any_rd = req_valid && !req_write;
  assign arr_rd = any_rd && (view != VIEW_REG);

  inkmask_pattern_reg #(.DW(DW), .PAT_RST(PAT_RST)) u_pat (
    .clk(clk), .rst_n(rst_n), .load(reg_wr), .din(req_wdata), .q(pattern)
  );

  inkmask_lane_gen #(.DW(DW)) u_lanes (
    .is_write(mem_wr), .view(view), .src(req_wdata), .pattern(pattern),
    .bit_we_n(arr_bit_we_n), .wdata(arr_wdata),
    .par_we_n(arr_par_we_n), .wpar(arr_wpar)
  );

  inkmask_parity_guard #(.DW(DW)) u_guard (
    .clk(clk), .rst_n(rst_n), .rd_req(any_rd), .rd_view(view),
    .arr_rdata(arr_rdata), .arr_rpar(arr_rpar), .pattern(pattern),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_par_err(rsp_par_err)
  );
endmodule

// File: rtl/inkmask_front_chk.sv
module inkmask_front_chk #(
  parameter int PHYS_W = 23,
  parameter int DW     = 32,
  localparam int AW    = PHYS_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic [DW-1:0]     req_wdata,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_rdata,
  input logic              rsp_par_err,
  input logic [PHYS_W-1:0] arr_addr,
  input logic              arr_rd,
  input logic [DW-1:0]     arr_bit_we_n,
  input logic              arr_par_we_n
);
  logic in_reg, in_ink, in_mem;
  assign in_reg = req_addr[AW-1];
  assign in_ink = !req_addr[AW-1] && req_addr[PHYS_W];
  assign in_mem = !req_addr[AW-1];

  a_r5_ink_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && in_ink) |-> (arr_bit_we_n == ~req_wdata));
  a_r6_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_mem) |-> (arr_addr == req_addr[PHYS_W-1:0]));
  a_r7_reg_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_reg) |-> (&arr_bit_we_n && arr_par_we_n && !arr_rd));
  a_r7_pattern_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && in_reg) ##1 (req_valid && !req_write && in_reg)
      |=> (rsp_rdata == $past(req_wdata, 2)));
  a_r8_ink_keeps_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && in_ink) |-> arr_par_we_n);
  a_r9_ink_read_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !(in_mem && !in_ink)) |=> !rsp_par_err);
  a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind inkmask_front inkmask_front_chk #(.PHYS_W(PHYS_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_par_err(rsp_par_err), .arr_addr(arr_addr),
  .arr_rd(arr_rd), .arr_bit_we_n(arr_bit_we_n), .arr_par_we_n(arr_par_we_n)
);

// File: tb/sim_inkmask_front.sv
`timescale 1ns/1ps
module sim_inkmask_front;
  localparam int PW = 6;
  localparam int DW = 32;
  localparam int AW = PW + 2;
  localparam int NW = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid, rsp_par_err, arr_rd, arr_par_we_n, arr_wpar;
  logic [DW-1:0] rsp_rdata, arr_bit_we_n, arr_wdata;
  logic [PW-1:0] arr_addr;
  logic [DW-1:0] arr_rdata;
  logic          arr_rpar;

  inkmask_front #(.PHYS_W(PW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_par_err(rsp_par_err), .arr_addr(arr_addr),
    .arr_rd(arr_rd), .arr_bit_we_n(arr_bit_we_n), .arr_wdata(arr_wdata),
    .arr_par_we_n(arr_par_we_n), .arr_wpar(arr_wpar),
    .arr_rdata(arr_rdata), .arr_rpar(arr_rpar)
  );

  // behavioural array: per-bit enables, one parity bit, registered read
  logic [DW-1:0] mem [NW];
  logic          par [NW];
  always_ff @(posedge clk) begin
    for (int i = 0; i < DW; i++)
      if (!arr_bit_we_n[i]) mem[arr_addr][i] <= arr_wdata[i];
    if (!arr_par_we_n) par[arr_addr] <= arr_wpar;
    if (arr_rd) begin
      arr_rdata <= mem[arr_addr];
      arr_rpar  <= par[arr_addr];
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [NW];
  logic          exp_par [NW];

  // snapshots
  logic [DW-1:0] s_we_n; logic s_pwe_n, s_wpar, s_rd;
  logic          r_vld, r_err; logic [DW-1:0] r_dat;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    s_we_n = arr_bit_we_n; s_pwe_n = arr_par_we_n; s_wpar = arr_wpar; s_rd = arr_rd;
    @(negedge clk);
    r_vld = rsp_valid; r_dat = rsp_rdata; r_err = rsp_par_err;
    req_valid = 1'b0;
  endtask

  function automatic logic [AW-1:0] rep_a(input int w); return AW'(w); endfunction
  function automatic logic [AW-1:0] ink_a(input int w); return AW'(w) | AW'(1 << PW); endfunction
  localparam logic [AW-1:0] REG_A = AW'(1 << (AW-1));

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] pats [4];
    pats[0] = '1; pats[1] = '0; pats[2] = 32'hAAAA5555; pats[3] = 32'h3C96E10F;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", DW'(rsp_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", DW'(rsp_valid), '0);
    op(1'b0, REG_A, '0);
    chk("R1 pattern reset", r_dat, '0);
    chk("R7 reg read no array strobe", DW'(s_rd), '0);

    // fill through replace window
    for (int w = 0; w < NW; w++) begin
      logic [DW-1:0] d;
      d = (DW'(w) * 32'h9E3779B1) ^ 32'h5A5A0000;
      op(1'b1, rep_a(w), d);
      chk("R5 replace enables", s_we_n, '0);
      chk("R8 replace parity we", DW'(s_pwe_n), '0);
      chk("R8 replace parity value", DW'(s_wpar), DW'(^d));
      chk("R10 no rsp on write", DW'(r_vld), '0);
      exp_mem[w] = d; exp_par[w] = ^d;
    end
    for (int w = 0; w < NW; w++) begin
      op(1'b0, rep_a(w), '0);
      chk("R10 replace read valid", DW'(r_vld), 1);
      chk("R2 replace data", r_dat, exp_mem[w]);
      chk("R9 clean parity", DW'(r_err), '0);
      op(1'b0, ink_a(w), '0);
      chk("R6 ink alias same word", r_dat, exp_mem[w]);
      chk("R10 ink read valid", DW'(r_vld), 1);
    end

    // ink writes per pattern
    for (int p = 0; p < 4; p++) begin
      op(1'b1, REG_A, pats[p]);
      chk("R7 reg write no enables", s_we_n, '1);
      chk("R7 reg write no parity", DW'(s_pwe_n), 1);
      op(1'b0, REG_A, '0);
      chk("R7 pattern readback", r_dat, pats[p]);
      for (int w = 0; w < NW; w++) begin
        logic [DW-1:0] src, old, nw;
        src = (DW'(w + 7 * p) * 32'h01000193) ^ {DW/2{2'(p)}};
        old = exp_mem[w];
        nw  = (old & ~src) | (pats[p] & src);
        op(1'b1, ink_a(w), src);
        chk("R5 ink enables", s_we_n, ~src);
        chk("R8 ink keeps parity", DW'(s_pwe_n), 1);
        exp_mem[w] = nw;
        op(1'b0, ink_a(w), '0);
        chk("R3 unmasked bits kept", r_dat & ~src, old & ~src);
        chk("R4 masked bits inked", r_dat & src, pats[p] & src);
        chk("R9 ink read no err", DW'(r_err), '0);
        op(1'b0, rep_a(w), '0);
        chk("R9 replace read parity", DW'(r_err), DW'((^nw) ^ exp_par[w]));
      end
    end

    // replace rewrite restores parity
    for (int w = 0; w < NW; w += 5) begin
      logic [DW-1:0] d;
      d = ~(DW'(w) << 3);
      op(1'b1, rep_a(w), d);
      exp_mem[w] = d; exp_par[w] = ^d;
      op(1'b0, rep_a(w), '0);
      chk("R2 rewrite data", r_dat, d);
      chk("R9 rewrite clears err", DW'(r_err), '0);
    end
    finish_run();
  end
endmodule